// File: doc/BRIEF.md
# Key-Sequence Write Guard for a Flash Control Register

This block keeps a flash controller's control register closed to software writes until a fixed two-word key has been written, in order, to a dedicated key register. A second key register, with its own sequencer, guards the two option-area bits (option program and option erase) inside that control register. Those bits stay frozen after the main unlock until the option key sequence has also been written.

Software talks to the block over a simple single-cycle register bus: a write strobe, a word address, write data, combinational read data, and an error response. Any misuse of a key register closes the register again and reports a bus error. Misuse means a wrong value, a value out of order, or a key write at a time when it is not expected. The rest of the controller sees the lock state, the option write enable and the whole control word on dedicated outputs.

The first key word is 0x45670123 and the second is 0xCDEF89AB. Word address 0 is the main key register, address 1 is the option key register, and address 2 is the control register.

Top module: `keyseq_wrlock`

## Requirements
- R1: After reset the control word reads with the lock bit (bit 7) at 1, the option write enable (bit 9) at 0, all other bits at 0, and `bus_err` low.
- R2: While the lock bit is 1, a write to the control register (address 2) changes no bit of the control word.
- R3: While locked, writing 0x45670123 to the main key register (address 0) and then 0xCDEF89AB as the next write to that register clears the lock bit in the cycle after the second write, with no bus error.
- R4: While unlocked, a control write with bit 7 at 1 sets the lock bit and clears the option write enable. That same write still loads the general bits [3:0].
- R5: While locked, a first key write other than 0x45670123, or a second key write other than 0xCDEF89AB, raises a bus error and leaves the register locked. The sequence then restarts, so a following correct pair unlocks.
- R6: Any write to the main key register while unlocked sets the lock bit, clears the option write enable and raises a bus error.
- R7: `bus_err` is high for exactly the one cycle after an offending key write, and is low in every other cycle.
- R8: While unlocked, a control write always loads the general bits [3:0]. It loads the option program bit (bit 4) and the option erase bit (bit 5) only when the option write enable is 1.
- R9: While unlocked with the option write enable at 0, writing 0x45670123 and then 0xCDEF89AB to the option key register (address 1) sets the option write enable in the cycle after the second write.
- R10: An option key write raises a bus error and leaves the option write enable at 0, without changing the lock bit, in three cases: it carries a wrong value, it arrives while locked, or it arrives while the option write enable is already 1.
- R11: While unlocked, a control write with bit 9 at 0 clears the option write enable. A control write with bit 9 at 1 never sets it.
- R12: Reads of addresses 0 and 1 return 0, and a read of address 2 returns the control word. Addresses 3 to 15 read 0, and writes to them change nothing and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| bus_err | output | 1 | Error response, one cycle after an offending write |
| ctl_locked | output | 1 | Control register lock state |
| opt_wr_en | output | 1 | Option program/erase write enable |
| ctl_word | output | DATA_W (32) | Current control register contents |

## Verification
The bench sweeps every ordered pair drawn from the two keys and three wrong words into both key registers. It compares each result with a model built from the requirements. This catches a sequencer that accepts the keys in reverse order, one that keeps a stale first key after an error, and one that unlocks on a repeated first key. A design that got any of these wrong would open the register on a bad pair, or stay shut after a good one.

The bench writes key registers while unlocked, and option keys while locked or already enabled. A design that missed these cases would leave the register open, or would leave the option bits writable with no bus error. The bench also drives every combination of the general and option bits with the option enable both off and on. This exposes option bits that leak through while protected, or a bit 9 write that wrongly sets the enable.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
    localparam int GEN_W    = 4;
    localparam int GEN_LSB  = 0;
    localparam int OPG_BIT  = 4;
    localparam int OER_BIT  = 5;
    localparam int LK_BIT   = 7;
    localparam int OWEN_BIT = 9;

    typedef struct packed {
        logic             lock;
        logic             owen;
        logic             opg;
        logic             oer;
        logic [GEN_W-1:0] gen;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{lock: 1'b1, owen: 1'b0, opg: 1'b0, oer: 1'b0, gen: '0};

    typedef struct packed {
        logic got_first;
    } kseq_state_t;

    typedef struct packed {
        logic err;
    } resp_state_t;
endpackage

// File: rtl/keylock_kseq.sv
module keylock_kseq #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_A  = '0,
    parameter logic [DATA_W-1:0] KEY_B  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              arm_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              done_o,
    output logic              bad_o
);
    import keylock_pkg::*;

    kseq_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        done_o = 1'b0;
        bad_o  = 1'b0;
        if (!arm_i) begin
            nxt_d.got_first = 1'b0;
        end
        if (wr_i) begin
            if (!arm_i) begin
                bad_o = 1'b1;
            end else if (!cur_q.got_first) begin
                if (data_i == KEY_A) begin
                    nxt_d.got_first = 1'b1;
                end else begin
                    bad_o = 1'b1;
                end
            end else begin
                nxt_d.got_first = 1'b0;
                if (data_i == KEY_B) begin
                    done_o = 1'b1;
                end else begin
                    bad_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R5: a second key write always returns the sequencer to its start
    p_restart_after_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && cur_q.got_first) |=> !cur_q.got_first);

    // R3: a first-key acceptance only follows an armed write of the first key
    p_first_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.got_first) |-> $past(wr_i && arm_i && data_i == KEY_A));
endmodule

// File: rtl/keylock_ctlreg.sv
module keylock_ctlreg (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [keylock_pkg::GEN_W-1:0]  gen_i,
    input  logic                           opg_i,
    input  logic                           oer_i,
    input  logic                           lk_i,
    input  logic                           owen_i,
    input  logic                           main_done_i,
    input  logic                           main_bad_i,
    input  logic                           opt_done_i,
    input  logic                           opt_bad_i,
    output keylock_pkg::ctl_state_t        state_o
);
    import keylock_pkg::*;

    ctl_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_i && !cur_q.lock) begin
            nxt_d.gen = gen_i;
            if (cur_q.owen) begin
                nxt_d.opg = opg_i;
                nxt_d.oer = oer_i;
            end
            if (!owen_i) begin
                nxt_d.owen = 1'b0;
            end
            if (lk_i) begin
                nxt_d.lock = 1'b1;
            end
        end
        if (opt_done_i) begin
            nxt_d.owen = 1'b1;
        end
        if (opt_bad_i) begin
            nxt_d.owen = 1'b0;
        end
        if (main_bad_i) begin
            nxt_d.lock = 1'b1;
        end
        if (main_done_i) begin
            nxt_d.lock = 1'b0;
        end
        if (nxt_d.lock) begin
            nxt_d.owen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= CTL_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o = cur_q;

    // R8: protected option bits hold while the enable is off
    p_opt_bits_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.owen && !opt_done_i) |=> ($stable(cur_q.opg) && $stable(cur_q.oer)));

    // R11: a control write with the enable bit at 0 leaves the enable clear
    p_owen_sw_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !cur_q.lock && !owen_i) |=> !cur_q.owen);

    // R4: relocking always drops the option enable
    p_lock_drops_owen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.lock |-> !cur_q.owen);
endmodule

// File: rtl/keyseq_wrlock.sv
module keyseq_wrlock #(
    parameter int                DATA_W      = 32,
    parameter int                ADDR_W      = 4,
    parameter logic [DATA_W-1:0] KEY_FIRST   = 'h45670123,
    parameter logic [DATA_W-1:0] KEY_SECOND  = 'hCDEF89AB,
    parameter int                ADDR_KEY    = 0,
    parameter int                ADDR_OPTKEY = 1,
    parameter int                ADDR_CTL    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              ctl_locked,
    output logic              opt_wr_en,
    output logic [DATA_W-1:0] ctl_word
);
    import keylock_pkg::*;

    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(ADDR_KEY);
    localparam logic [ADDR_W-1:0] A_OPT = ADDR_W'(ADDR_OPTKEY);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);

    logic        hit_key, hit_opt, hit_ctl;
    logic        wr_key, wr_opt, wr_ctl;
    logic        main_done, main_bad, opt_done, opt_bad;
    ctl_state_t  st;
    resp_state_t rsp_q, rsp_d;

    assign hit_key = (bus_addr == A_KEY);
    assign hit_opt = (bus_addr == A_OPT);
    assign hit_ctl = (bus_addr == A_CTL);
    assign wr_key  = bus_we && hit_key;
    assign wr_opt  = bus_we && hit_opt;
    assign wr_ctl  = bus_we && hit_ctl;

    keylock_kseq #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_FIRST),
        .KEY_B  (KEY_SECOND)
    ) u_main_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_key),
        .arm_i  (st.lock),
        .data_i (bus_wdata),
        .done_o (main_done),
        .bad_o  (main_bad)
    );

    keylock_kseq #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_FIRST),
        .KEY_B  (KEY_SECOND)
    ) u_opt_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_opt),
        .arm_i  (!st.lock && !st.owen),
        .data_i (bus_wdata),
        .done_o (opt_done),
        .bad_o  (opt_bad)
    );

    keylock_ctlreg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_ctl),
        .gen_i       (bus_wdata[GEN_LSB +: GEN_W]),
        .opg_i       (bus_wdata[OPG_BIT]),
        .oer_i       (bus_wdata[OER_BIT]),
        .lk_i        (bus_wdata[LK_BIT]),
        .owen_i      (bus_wdata[OWEN_BIT]),
        .main_done_i (main_done),
        .main_bad_i  (main_bad),
        .opt_done_i  (opt_done),
        .opt_bad_i   (opt_bad),
        .state_o     (st)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.err = main_bad || opt_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    always_comb begin
        ctl_word                     = '0;
        ctl_word[GEN_LSB +: GEN_W]   = st.gen;
        ctl_word[OPG_BIT]            = st.opg;
        ctl_word[OER_BIT]            = st.oer;
        ctl_word[LK_BIT]             = st.lock;
        ctl_word[OWEN_BIT]           = st.owen;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctl) begin
            bus_rdata = ctl_word;
        end
    end

    assign bus_err    = rsp_q.err;
    assign ctl_locked = st.lock;
    assign opt_wr_en  = st.owen;

    // R2: a locked control register ignores control writes
    p_locked_ctl_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_locked) |=> $stable(ctl_word));

    // R3: the lock only falls after the second key word on the main key register
    p_unlock_on_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_locked) |-> $past(wr_key && bus_wdata == KEY_SECOND));

    // R4: software relock takes effect on the next cycle
    p_sw_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !ctl_locked && bus_wdata[LK_BIT]) |=> (ctl_locked && !opt_wr_en));

    // R5: a word that is neither key is always rejected
    p_bad_word_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && bus_wdata != KEY_FIRST && bus_wdata != KEY_SECOND) |=> (bus_err && ctl_locked));

    // R6: a key write while open relocks with an error
    p_open_key_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && !ctl_locked) |=> (bus_err && ctl_locked && !opt_wr_en));

    // R7: an error response always follows a key register write
    p_err_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_we && (hit_key || hit_opt)));

    // R9: the option enable rises only from an unlocked second option key
    p_owen_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(opt_wr_en) |-> $past(!ctl_locked && wr_opt && bus_wdata == KEY_SECOND));

    // R10: an option key write while enabled drops the enable with an error
    p_opt_rewrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_opt && opt_wr_en) |=> (bus_err && !opt_wr_en));
endmodule

// File: tb/sim_keyseq_wrlock.sv
module sim_keyseq_wrlock;
    localparam logic [31:0] K1 = 32'h45670123;
    localparam logic [31:0] K2 = 32'hCDEF89AB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ctl_locked;
    logic        opt_wr_en;
    logic [31:0] ctl_word;

    int checks = 0;
    int errors = 0;

    logic       m_lock, m_owen, m_opg, m_oer, m_got, m_ogot, exp_err;
    logic [3:0] m_gen;

    always #10 clk = ~clk;

    keyseq_wrlock u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .ctl_locked (ctl_locked),
        .opt_wr_en  (opt_wr_en),
        .ctl_word   (ctl_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word();
        return (32'(m_owen) << 9) | (32'(m_lock) << 7) | (32'(m_oer) << 5)
             | (32'(m_opg) << 4) | 32'(m_gen);
    endfunction

    function automatic logic [31:0] key_val(input int i);
        case (i)
            0: return K1;
            1: return K2;
            2: return 32'h0;
            3: return K1 ^ 32'h1;
            default: return ~K2;
        endcase
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        exp_err = 1'b0;
        if (a == 4'd0) begin
            if (!m_lock) begin
                exp_err = 1'b1; m_lock = 1'b1; m_owen = 1'b0; m_got = 1'b0;
            end else if (!m_got) begin
                if (d == K1) m_got = 1'b1; else exp_err = 1'b1;
            end else begin
                m_got = 1'b0;
                if (d == K2) m_lock = 1'b0; else exp_err = 1'b1;
            end
        end else if (a == 4'd1) begin
            if (m_lock || m_owen) begin
                exp_err = 1'b1; m_owen = 1'b0; m_ogot = 1'b0;
            end else if (!m_ogot) begin
                if (d == K1) m_ogot = 1'b1; else exp_err = 1'b1;
            end else begin
                m_ogot = 1'b0;
                if (d == K2) m_owen = 1'b1; else exp_err = 1'b1;
            end
        end else if (a == 4'd2) begin
            if (!m_lock) begin
                m_gen = d[3:0];
                if (m_owen) begin m_opg = d[4]; m_oer = d[5]; end
                if (!d[9]) m_owen = 1'b0;
                if (d[7]) begin m_lock = 1'b1; m_owen = 1'b0; end
            end
        end
        if (m_lock || m_owen) m_ogot = 1'b0;
        if (!m_lock) m_got = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'd2;
        model_write(a, d);
        #1;
        check({tag, " err"}, 32'(bus_err), 32'(exp_err));
        check({tag, " lock"}, 32'(ctl_locked), 32'(m_lock));
        check({tag, " owen"}, 32'(opt_wr_en), 32'(m_owen));
        check({tag, " word"}, bus_rdata, exp_word());
        @(negedge clk);
        check("R7 err pulse width", 32'(bus_err), 32'd0);
    endtask

    task automatic go_unlocked();
        if (!m_lock) wr(4'd2, 32'h0000_0200 | 32'(m_gen), "R4 prep");
        if (!m_lock) wr(4'd2, 32'h0000_0080, "R4 relock");
        if (m_got) wr(4'd0, 32'h0, "R5 flush");
        wr(4'd0, K1, "R3 first");
        wr(4'd0, K2, "R3 second");
    endtask

    initial begin
        m_lock = 1'b1; m_owen = 1'b0; m_opg = 1'b0; m_oer = 1'b0;
        m_got = 1'b0; m_ogot = 1'b0; exp_err = 1'b0; m_gen = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_addr = 4'd2; #1;
        check("R1 reset word", bus_rdata, 32'h0000_0080);
        check("R1 reset err", 32'(bus_err), 32'd0);
        check("R1 reset owen", 32'(opt_wr_en), 32'd0);

        // R2: locked control writes ignored
        for (int v = 0; v < 16; v++) wr(4'd2, 32'h0000_0230 | 32'(v), "R2 locked write");

        // R3 / R5: all ordered key pairs from a locked start
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                if (!m_lock) wr(4'd2, 32'h0000_0080, "R4 relock");
                wr(4'd0, key_val(i), "R5 key pair A");
                wr(4'd0, key_val(j), "R5 key pair B");
            end
        end
        // R5: restart after a bad pair
        if (!m_lock) wr(4'd2, 32'h0000_0080, "R4 relock");
        wr(4'd0, K1, "R5 first");
        wr(4'd0, K1, "R5 repeated first");
        wr(4'd0, K1, "R5 restart first");
        wr(4'd0, K2, "R5 restart second");
        check("R5 unlocked after restart", 32'(ctl_locked), 32'd0);

        // R6: key write while open
        wr(4'd0, K1, "R6 open key write");
        go_unlocked();
        wr(4'd0, K2, "R6 open key write");

        // R10: option key while locked
        wr(4'd1, K1, "R10 locked opt key");

        // R9 / R10: all ordered option key pairs
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                if (m_lock) go_unlocked();
                if (m_owen) wr(4'd2, 32'h0, "R11 clear owen");
                wr(4'd1, key_val(i), "R9 opt pair A");
                wr(4'd1, key_val(j), "R9 opt pair B");
            end
        end
        if (m_lock) go_unlocked();
        if (m_owen) wr(4'd2, 32'h0, "R11 clear owen");
        wr(4'd1, K1, "R9 opt first");
        wr(4'd1, K2, "R9 opt second");
        check("R9 owen set", 32'(opt_wr_en), 32'd1);
        wr(4'd1, K1, "R10 opt key while enabled");

        // R8: general and option bits, enable off then on
        for (int e = 0; e < 2; e++) begin
            if (m_lock) go_unlocked();
            if (e == 1 && !m_owen) begin
                wr(4'd1, K1, "R9 opt first");
                wr(4'd1, K2, "R9 opt second");
            end
            for (int d = 0; d < 64; d++) wr(4'd2, 32'h0000_0200 | 32'(d), "R8 ctl data");
        end

        // R11: bit 9 at 1 never sets the enable
        wr(4'd2, 32'h0, "R11 clear");
        wr(4'd2, 32'h0000_0200, "R11 no set");

        // R4: relock loads general bits and clears enable
        wr(4'd1, K1, "R9 opt first");
        wr(4'd1, K2, "R9 opt second");
        wr(4'd2, 32'h0000_028A, "R4 relock with data");

        // R12: reads and unmapped addresses
        go_unlocked();
        for (int a = 3; a < 16; a++) wr(4'(a), K1, "R12 unmapped write");
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            bus_addr = 4'(a); #1;
            check("R12 read", bus_rdata, (a == 2) ? exp_word() : 32'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule